// File: doc/BRIEF.md
# Boot-Region Access Filter with Read Overlay

This block sits beside a CPU's data path and watches the physical address of each access. It has two guards. The first is a low-page guard: once it is armed, any data access whose address falls in the first 4 KiB of the address space raises a trap pulse, and a trapped write is not passed on to memory. The second is a read overlay: once it is armed, data reads that hit the boot ROM window return a programmable 32-bit word in place of the data coming back from the ROM.

The block also holds one FIQ mask bit per core, which drive the interrupt controller directly. Software programs all of this through a small register port. Every register bit is stored and can be read back, including bits that have no function. The trap, the read-data path and the write forward are all combinational on the access cycle. A register write takes effect from the clock edge that samples it.

Top module: `boot_region_filter`

## Requirements
- R1: With bit 0 of the low-page control register (register index 0) set, a valid data access to any address from 0x0000 to 0x0FFF drives `trap_o` high in that same cycle, and in no other cycle.
- R2: Instruction fetches (`acc_is_data_i` = 0), accesses at address 0x1000 or above, and cycles with `acc_valid_i` low never raise `trap_o`.
- R3: After reset the low-page control register reads 0x00010000, and the low-page guard is disarmed.
- R4: `mem_wr_en_o` is high exactly when a valid write access is not trapped. A trapped write is never forwarded.
- R5: With bit 0 of the overlay control register (register index 2) set, a valid data read inside the boot ROM window (default base 0xFFFF0000, size 64 KiB) returns the overlay value register (register index 3) on `rdata_o`.
- R6: `rdata_o` equals `mem_rdata_i` whenever the overlay is disarmed, the address lies outside the window, the access is an instruction fetch or a write, or `acc_valid_i` is low.
- R7: The FIQ mask register (register index 1) drives `fiq_mask_o`. Bit N masks core N. It resets to all ones (0xF for four cores), and bits above the core count read as zero.
- R8: Control bits with no function (every bit except bit 0 of registers 0 and 2) are stored and read back unchanged, and they do not affect the trap or the overlay.
- R9: `cfg_rdata_o` always shows the register selected by `cfg_addr_i`. A write updates that register at the next clock edge, and registers that are not written keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_valid_i | input | 1 | An access is present this cycle |
| acc_is_data_i | input | 1 | 1 = data access, 0 = instruction fetch |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 32 | Physical address of the access |
| mem_rdata_i | input | 32 | Read data returned by memory |
| rdata_o | output | 32 | Read data passed to the CPU, possibly replaced by the overlay |
| mem_wr_en_o | output | 1 | Write enable forwarded to memory |
| trap_o | output | 1 | Low-page trap pulse |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register index: 0 low-page control, 1 FIQ mask, 2 overlay control, 3 overlay value |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read-back of the selected register |
| fiq_mask_o | output | 4 | Per-core FIQ mask lines |

## Verification
Some properties are checked by assertions on every cycle. A trap only occurs for an armed guard and a low-page address. No write is forwarded in a trapped cycle. Read data passes through untouched while the overlay is disarmed. Registers hold their value when they are not written. A write to the overlay value lands on the next edge.

Other behaviour can only be shown by the bench's scenarios, run against its behavioural model. These cover the reset values, the exact edges of the low page and of the ROM window, instruction fetches and writes inside the window, and the per-core mapping of the FIQ mask. They also show that function-less bits are kept yet stay inert.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    REG_LOWCTL  = 2'd0,
    REG_FIQMASK = 2'd1,
    REG_OVLCTL  = 2'd2,
    REG_OVLVAL  = 2'd3
  } brf_reg_e;

  localparam logic [REG_W-1:0] LOWCTL_RST = 32'h0001_0000;
  localparam logic [REG_W-1:0] OVLCTL_RST = 32'h0000_0000;
  localparam logic [REG_W-1:0] OVLVAL_RST = 32'h0000_0000;
endpackage

// File: rtl/brf_regs.sv
module brf_regs
  import brf_pkg::*;
#(
  parameter int unsigned N_CORES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               low_en_o,
  output logic               ovl_en_o,
  output logic [REG_W-1:0]   ovl_val_o,
  output logic [N_CORES-1:0] fiq_mask_o
);
  localparam int unsigned FIQ_PAD = REG_W - N_CORES;

  logic [REG_W-1:0] lowctl_q, lowctl_d;
  logic [REG_W-1:0] ovlctl_q, ovlctl_d;
  logic [REG_W-1:0] ovlval_q, ovlval_d;
  logic [N_CORES-1:0] fiq_q;
  logic en_low, en_fiq, en_oc, en_ov;

  // write decode: one clock enable per register
  always_comb begin
    en_low = we_i && (brf_reg_e'(addr_i) == REG_LOWCTL);
    en_fiq = we_i && (brf_reg_e'(addr_i) == REG_FIQMASK);
    en_oc  = we_i && (brf_reg_e'(addr_i) == REG_OVLCTL);
    en_ov  = we_i && (brf_reg_e'(addr_i) == REG_OVLVAL);
    lowctl_d = en_low ? wdata_i : lowctl_q;
    ovlctl_d = en_oc  ? wdata_i : ovlctl_q;
    ovlval_d = en_ov  ? wdata_i : ovlval_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowctl_q <= LOWCTL_RST;
      ovlctl_q <= OVLCTL_RST;
      ovlval_q <= OVLVAL_RST;
    end else begin
      lowctl_q <= lowctl_d;
      ovlctl_q <= ovlctl_d;
      ovlval_q <= ovlval_d;
    end
  end

  // one mask flop per core, each resetting to masked
  for (genvar c = 0; c < N_CORES; c++) begin : g_fiq
    logic bit_d;
    always_comb bit_d = en_fiq ? wdata_i[c] : fiq_q[c];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fiq_q[c] <= 1'b1;
      else        fiq_q[c] <= bit_d;
    end
  end

  always_comb begin
    unique case (brf_reg_e'(addr_i))
      REG_LOWCTL:  rdata_o = lowctl_q;
      REG_FIQMASK: rdata_o = {{FIQ_PAD{1'b0}}, fiq_q};
      REG_OVLCTL:  rdata_o = ovlctl_q;
      default:     rdata_o = ovlval_q;
    endcase
  end

  assign low_en_o   = lowctl_q[0];
  assign ovl_en_o   = ovlctl_q[0];
  assign ovl_val_o  = ovlval_q;
  assign fiq_mask_o = fiq_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(lowctl_q) && $stable(ovlctl_q) && $stable(ovlval_q) && $stable(fiq_q));
  p_ovlval_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == 2'd3) |=> ovlval_q == $past(wdata_i));
endmodule

// File: rtl/brf_trap.sv
module brf_trap #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LOW_BYTES = 4096
) (
  input  logic              valid_i,
  input  logic              is_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic              trap_o
);
  localparam logic [ADDR_W-1:0] LOW_LIMIT = ADDR_W'(LOW_BYTES);

  logic in_low;

  always_comb begin
    in_low = addr_i < LOW_LIMIT;
    trap_o = valid_i && is_data_i && en_i && in_low;
  end
endmodule

// File: rtl/brf_overlay.sv
module brf_overlay #(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       DATA_W   = 32,
  parameter logic [ADDR_W-1:0] ROM_BASE = 32'hFFFF_0000,
  parameter logic [ADDR_W:0]   ROM_SIZE = 33'h0_0001_0000
) (
  input  logic              valid_i,
  input  logic              is_data_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] ovl_val_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W:0] WIN_LO = {1'b0, ROM_BASE};
  localparam logic [ADDR_W:0] WIN_HI = WIN_LO + ROM_SIZE;

  logic [ADDR_W:0] addr_x;
  logic in_win, hit;

  always_comb begin
    addr_x  = {1'b0, addr_i};
    in_win  = (addr_x >= WIN_LO) && (addr_x < WIN_HI);
    hit     = valid_i && is_data_i && !write_i && en_i && in_win;
    rdata_o = hit ? ovl_val_i : mem_rdata_i;
  end
endmodule

// File: rtl/boot_region_filter.sv
module boot_region_filter
  import brf_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       N_CORES   = 4,
  parameter int unsigned       LOW_BYTES = 4096,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 32'hFFFF_0000,
  parameter logic [ADDR_W:0]   ROM_SIZE  = 33'h0_0001_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid_i,
  input  logic               acc_is_data_i,
  input  logic               acc_write_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [REG_W-1:0]   mem_rdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               mem_wr_en_o,
  output logic               trap_o,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_addr_i,
  input  logic [REG_W-1:0]   cfg_wdata_i,
  output logic [REG_W-1:0]   cfg_rdata_o,
  output logic [N_CORES-1:0] fiq_mask_o
);
  logic rst_meta_q, rst_sync_q;
  logic low_en, ovl_en;
  logic [REG_W-1:0] ovl_val;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  brf_regs #(.N_CORES(N_CORES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .low_en_o   (low_en),
    .ovl_en_o   (ovl_en),
    .ovl_val_o  (ovl_val),
    .fiq_mask_o (fiq_mask_o)
  );

  brf_trap #(.ADDR_W(ADDR_W), .LOW_BYTES(LOW_BYTES)) u_trap (
    .valid_i   (acc_valid_i),
    .is_data_i (acc_is_data_i),
    .addr_i    (acc_addr_i),
    .en_i      (low_en),
    .trap_o    (trap_o)
  );

  brf_overlay #(
    .ADDR_W(ADDR_W), .DATA_W(REG_W), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE)
  ) u_ovl (
    .valid_i     (acc_valid_i),
    .is_data_i   (acc_is_data_i),
    .write_i     (acc_write_i),
    .addr_i      (acc_addr_i),
    .en_i        (ovl_en),
    .ovl_val_i   (ovl_val),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (rdata_o)
  );

  assign mem_wr_en_o = acc_valid_i && acc_write_i && !trap_o;

  p_trap_armed_r1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    trap_o |-> low_en && acc_addr_i < ADDR_W'(LOW_BYTES));
  p_trap_data_only_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    trap_o |-> acc_valid_i && acc_is_data_i);
  p_no_fwd_on_trap_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    trap_o |-> !mem_wr_en_o);
  p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !ovl_en |-> rdata_o == mem_rdata_i);
endmodule

// File: tb/boot_region_filter_tb_top.sv
`timescale 1ns/1ps
module boot_region_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid_i, acc_is_data_i, acc_write_i;
  logic [31:0] acc_addr_i, mem_rdata_i, rdata_o;
  logic        mem_wr_en_o, trap_o;
  logic        cfg_we_i;
  logic [1:0]  cfg_addr_i;
  logic [31:0] cfg_wdata_i, cfg_rdata_o;
  logic [3:0]  fiq_mask_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_low, m_oc, m_ov;
  logic [3:0]  m_fiq;

  always #4 clk = ~clk;

  boot_region_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid_i(acc_valid_i), .acc_is_data_i(acc_is_data_i),
    .acc_write_i(acc_write_i), .acc_addr_i(acc_addr_i),
    .mem_rdata_i(mem_rdata_i), .rdata_o(rdata_o),
    .mem_wr_en_o(mem_wr_en_o), .trap_o(trap_o),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .fiq_mask_o(fiq_mask_o)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, bit d, bit w, logic [31:0] a, logic [31:0] md,
                      bit we, logic [1:0] ca, logic [31:0] cw);
    logic        e_trap, e_wr;
    logic [31:0] e_rd, e_cfg;
    acc_valid_i = v; acc_is_data_i = d; acc_write_i = w; acc_addr_i = a;
    mem_rdata_i = md; cfg_we_i = we; cfg_addr_i = ca; cfg_wdata_i = cw;
    #1;
    e_trap = v && d && m_low[0] && (a < 32'h1000);
    e_wr   = v && w && !e_trap;
    e_rd   = (v && d && !w && m_oc[0] && a >= 32'hFFFF_0000) ? m_ov : md;
    case (ca)
      2'd0: e_cfg = m_low;
      2'd1: e_cfg = {28'd0, m_fiq};
      2'd2: e_cfg = m_oc;
      default: e_cfg = m_ov;
    endcase
    check(tag, "trap_o", {31'd0, trap_o}, {31'd0, e_trap});
    check(tag, "mem_wr_en_o", {31'd0, mem_wr_en_o}, {31'd0, e_wr});
    check(tag, "rdata_o", rdata_o, e_rd);
    check(tag, "cfg_rdata_o", cfg_rdata_o, e_cfg);
    check(tag, "fiq_mask_o", {28'd0, fiq_mask_o}, {28'd0, m_fiq});
    @(posedge clk);
    if (we) begin
      case (ca)
        2'd0: m_low = cw;
        2'd1: m_fiq = cw[3:0];
        2'd2: m_oc = cw;
        default: m_ov = cw;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(string tag, logic [1:0] ca, logic [31:0] cw);
    step(tag, 0, 0, 0, 32'h0, 32'h0, 1, ca, cw);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_low = 32'h0001_0000; m_oc = 0; m_ov = 0; m_fiq = 4'hF;
    rst_n = 0;
    acc_valid_i = 0; acc_is_data_i = 0; acc_write_i = 0; acc_addr_i = 0;
    mem_rdata_i = 0; cfg_we_i = 0; cfg_addr_i = 0; cfg_wdata_i = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R3 / R7: reset values of every register
    for (int i = 0; i < 4; i++) step("R3", 0, 0, 0, 0, 0, 0, 2'(i), 0);
    step("R3", 1, 1, 0, 32'h0, 32'h1111_1111, 0, 0, 0);   // disarmed guard
    step("R7", 0, 0, 0, 0, 0, 0, 1, 0);

    // R1 / R2 / R4: low-page guard
    wr("R9", 0, 32'h0000_0001);
    step("R1", 1, 1, 0, 32'h0000_0000, 32'h2, 0, 0, 0);
    step("R1", 1, 1, 0, 32'h0000_0FFF, 32'h3, 0, 0, 0);
    step("R2", 1, 1, 0, 32'h0000_1000, 32'h4, 0, 0, 0);
    step("R2", 1, 0, 0, 32'h0000_0010, 32'h5, 0, 0, 0);
    step("R2", 0, 1, 0, 32'h0000_0010, 32'h6, 0, 0, 0);
    step("R4", 1, 1, 1, 32'h0000_0800, 32'h7, 0, 0, 0);
    step("R4", 1, 1, 1, 32'h0000_2000, 32'h8, 0, 0, 0);
    step("R4", 1, 0, 1, 32'h0000_0004, 32'h9, 0, 0, 0);

    // R5 / R6: read overlay
    wr("R9", 3, 32'hDEAD_BEEF);
    step("R6", 1, 1, 0, 32'hFFFF_0000, 32'h1234_5678, 0, 3, 0);
    wr("R9", 2, 32'h0000_0001);
    step("R5", 1, 1, 0, 32'hFFFF_0000, 32'h1234_5678, 0, 2, 0);
    step("R5", 1, 1, 0, 32'hFFFF_FFFC, 32'h1234_5678, 0, 2, 0);
    step("R6", 1, 1, 0, 32'hFFFE_FFFC, 32'h1234_5678, 0, 2, 0);
    step("R6", 1, 0, 0, 32'hFFFF_0100, 32'h1234_5678, 0, 2, 0);
    step("R6", 1, 1, 1, 32'hFFFF_0100, 32'h1234_5678, 0, 2, 0);
    step("R6", 0, 1, 0, 32'hFFFF_0100, 32'h1234_5678, 0, 2, 0);

    // R7: per-core mask bits
    wr("R7", 1, 32'h0000_0005);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 0);
    wr("R7", 1, 32'hFFFF_FFF2);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 0);

    // R8: function-less bits kept but inert
    wr("R8", 0, 32'hABCD_0000);
    step("R8", 1, 1, 0, 32'h0000_0040, 32'hA, 0, 0, 0);
    wr("R8", 2, 32'h8000_0000);
    step("R8", 1, 1, 0, 32'hFFFF_0040, 32'hB, 0, 2, 0);

    // R9: mixed traffic against the model
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      a = (sel == 0) ? ($urandom & 32'h0000_1FFF) :
          (sel == 1) ? (32'hFFFE_0000 | ($urandom & 32'h0001_FFFF)) : $urandom;
      step("R9", 1'($urandom), 1'($urandom), 1'($urandom), a, $urandom,
           ($urandom_range(0, 5) == 0), 2'($urandom), $urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule